// File: doc/BRIEF.md
# AC-link Command Slot Decoder

This block sits on the codec side of an AC-link serial link. It receives the controller's serial output stream, one bit per bit clock, and aligns to each frame on the rising edge of SYNC. From every frame it captures the 16-bit tag slot and the two 20-bit command slots that follow. It then decides whether the frame carries a register read or write addressed to this codec.

The codec's role comes from a strapped 2-bit ID. A codec strapped to 00 is the primary. It takes a command only when the frame's ID field is 00 and the command tag bits are set. A codec strapped to any other value is a secondary. It ignores the command tag bits and accepts a frame whose ID field equals its strap. Every accepted frame must also have its frame-valid bit set.

When a frame is accepted, the block emits a one-cycle access strobe together with a read flag, a 7-bit register address and 16-bit write data. It leaves these outputs unchanged until the next accepted frame. A register file placed downstream uses these outputs directly.

Top module: `aclink_cmd_decoder`

## Requirements
- R1: The bit sampled on the first clock edge at which `sync_i` is high after being low is frame bit 0, which is tag-slot bit 15. The tag slot is 16 bits wide and is followed by two 20-bit command slots. Every slot is received MSB first.
- R2: When tag bit 15 (frame valid) is 0, no strobe is produced, whatever the ID field and the other tag bits hold.
- R3: With a strap of 00, a frame is accepted when frame valid is 1, the ID field (tag bits 1:0) is 00 and tag bit 14 (command address valid) is 1. A write must also have tag bit 13 (command data valid) set. A read does not need tag bit 13.
- R4: With a strap of 00, a frame is rejected when tag bit 14 is 0, when the ID field is not 00, or when it is a write and tag bit 13 is 0.
- R5: With a non-zero strap, tag bits 14 and 13 are ignored. A frame whose ID field equals the strap and whose frame-valid bit is 1 is accepted, even when no other tag bit is set.
- R6: With a non-zero strap, a frame whose ID field differs from the strap is rejected. This includes an ID field of 00 with tags set.
- R7: In an accepted frame, command slot 1 bit 19 is the read flag (1 = read) and bits 18:12 are the register address. Command slot 2 bits 19:4 are the write data. All other bits of both slots have no effect.
- R8: For each accepted frame, `acc_valid_o` is high for exactly one clock. It rises at the edge that follows the edge sampling frame bit 55, the last bit of slot 2.
- R9: On an accepted read, `acc_wdata_o` is driven to zero.
- R10: After reset the strobe, read flag, address and data outputs are zero. The read flag, address and data outputs change only together with a strobe.
- R11: A rising edge of `sync_i` at any point restarts frame alignment at bit 0. A frame cut short before slot 2 ends produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync from the controller |
| sdo_i | input | 1 | Serial data from the controller, one bit per clock |
| codec_id_i | input | 2 | Strapped codec ID (00 = primary) |
| acc_valid_o | output | 1 | One-cycle register access strobe |
| acc_read_o | output | 1 | 1 = read, 0 = write |
| acc_addr_o | output | 7 | Register address |
| acc_wdata_o | output | 16 | Write data, zero on reads |

## Verification
The bench targets the role split. A primary frame carrying a read with only the address tag must be accepted. A design that demands both tags would drop it, while a secondary that honours the tags would reject a bare ID-matched frame. Frames with the valid bit cleared but a perfect ID and tags catch a decoder that skips the frame-valid gate. A secondary strap seeing ID 00 with full tags catches a decoder that treats every ID-00 frame as its own. A truncated frame followed at once by a new SYNC rise checks that the bit counter restarts, and checks the strobe timing against the first bit of slot 3. Off-by-one alignment shows up as shifted addresses and data across the random frames.

// File: rtl/aclink_cmd_pkg.sv
`timescale 1ns/1ps
package aclink_cmd_pkg;
  localparam int FRAME_BITS = 256;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 16;
  localparam int ID_W       = 2;
endpackage

// File: rtl/aclink_frame_timer.sv
`timescale 1ns/1ps
module aclink_frame_timer #(
  parameter int FRAME_BITS = aclink_cmd_pkg::FRAME_BITS,
  parameter int TAG_BITS   = aclink_cmd_pkg::TAG_BITS,
  parameter int SLOT_BITS  = aclink_cmd_pkg::SLOT_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic tag_en_o,
  output logic s1_en_o,
  output logic s2_en_o,
  output logic s2_last_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] S1_FIRST = CNT_W'(TAG_BITS);
  localparam logic [CNT_W-1:0] S2_FIRST = CNT_W'(TAG_BITS + SLOT_BITS);
  localparam logic [CNT_W-1:0] S2_END   = CNT_W'(TAG_BITS + 2 * SLOT_BITS);

  logic             sync_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frame_start;
  logic             bit_vld;
  logic [CNT_W-1:0] bit_idx;

  assign frame_start = sync_i & ~sync_q;
  assign bit_vld     = frame_start | active_q;
  assign bit_idx     = frame_start ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q <= sync_i;
      if (bit_vld) begin
        cnt_q    <= bit_idx;
        active_q <= (bit_idx != LAST_IDX);
      end
    end
  end

  assign tag_en_o  = bit_vld && (bit_idx < S1_FIRST);
  assign s1_en_o   = bit_vld && (bit_idx >= S1_FIRST) && (bit_idx < S2_FIRST);
  assign s2_en_o   = bit_vld && (bit_idx >= S2_FIRST) && (bit_idx < S2_END);
  assign s2_last_o = bit_vld && (bit_idx == S2_END - CNT_W'(1));

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_i) |=> (cnt_q == '0) && active_q);

  assert_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !(sync_i && !sync_q)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/aclink_slot_shift.sv
`timescale 1ns/1ps
module aclink_slot_shift #(
  parameter int W = aclink_cmd_pkg::SLOT_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/aclink_cmd_qualifier.sv
`timescale 1ns/1ps
module aclink_cmd_qualifier #(
  parameter int TAG_BITS  = aclink_cmd_pkg::TAG_BITS,
  parameter int SLOT_BITS = aclink_cmd_pkg::SLOT_BITS,
  parameter int ADDR_W    = aclink_cmd_pkg::ADDR_W,
  parameter int DATA_W    = aclink_cmd_pkg::DATA_W,
  parameter int ID_W      = aclink_cmd_pkg::ID_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 s2_last_i,
  input  logic [TAG_BITS-1:0]  tag_i,
  input  logic [SLOT_BITS-1:0] s1_i,
  input  logic [SLOT_BITS-1:0] s2_i,
  input  logic [ID_W-1:0]      codec_id_i,
  output logic                 acc_valid_o,
  output logic                 acc_read_o,
  output logic [ADDR_W-1:0]    acc_addr_o,
  output logic [DATA_W-1:0]    acc_wdata_o
);
  localparam int FV_BIT = TAG_BITS - 1;
  localparam int T1_BIT = TAG_BITS - 2;
  localparam int T2_BIT = TAG_BITS - 3;
  localparam int RD_BIT = SLOT_BITS - 1;
  localparam int A_LO   = SLOT_BITS - 1 - ADDR_W;
  localparam int D_LO   = SLOT_BITS - DATA_W;

  logic            done_q;
  logic            accept;
  logic            is_read;
  logic [ID_W-1:0] id_field;
  logic            unused_bits;

  assign id_field    = tag_i[ID_W-1:0];
  assign is_read     = s1_i[RD_BIT];
  assign unused_bits = ^{tag_i[T2_BIT-1:ID_W], s1_i[A_LO-1:0], s2_i[D_LO-1:0]};

  always_comb begin
    if (!tag_i[FV_BIT])
      accept = 1'b0;
    else if (codec_id_i == '0)
      accept = (id_field == '0) && tag_i[T1_BIT] && (is_read || tag_i[T2_BIT]);
    else
      accept = (id_field == codec_id_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      acc_valid_o <= 1'b0;
      acc_read_o  <= 1'b0;
      acc_addr_o  <= '0;
      acc_wdata_o <= '0;
    end else begin
      done_q      <= s2_last_i;
      acc_valid_o <= done_q && accept;
      if (done_q && accept) begin
        acc_read_o  <= is_read;
        acc_addr_o  <= s1_i[RD_BIT-1:A_LO];
        acc_wdata_o <= is_read ? '0 : s2_i[SLOT_BITS-1:D_LO];
      end
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |=> !acc_valid_o);

  assert_frame_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> $past(tag_i[FV_BIT]));

  assert_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && acc_read_o) |-> (acc_wdata_o == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_o |-> ($stable(acc_addr_o) && $stable(acc_wdata_o) && $stable(acc_read_o)));

  assert_sec_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && $past(codec_id_i) != '0) |-> ($past(tag_i[ID_W-1:0]) == $past(codec_id_i)));
endmodule

// File: rtl/aclink_cmd_decoder.sv
`timescale 1ns/1ps
module aclink_cmd_decoder
  import aclink_cmd_pkg::*;
#(
  parameter int FRAME_W = FRAME_BITS,
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int IDW     = ID_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic           sdo_i,
  input  logic [IDW-1:0] codec_id_i,
  output logic           acc_valid_o,
  output logic           acc_read_o,
  output logic [AW-1:0]  acc_addr_o,
  output logic [DW-1:0]  acc_wdata_o
);
  logic              tag_en, s1_en, s2_en, s2_last;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] s1_q, s2_q;

  aclink_frame_timer #(
    .FRAME_BITS(FRAME_W), .TAG_BITS(TAG_W), .SLOT_BITS(SLOT_W)
  ) u_timer (
    .clk_i, .rst_ni, .sync_i,
    .tag_en_o(tag_en), .s1_en_o(s1_en), .s2_en_o(s2_en), .s2_last_o(s2_last)
  );

  aclink_slot_shift #(.W(TAG_W)) u_tag (
    .clk_i, .rst_ni, .en_i(tag_en), .bit_i(sdo_i), .q_o(tag_q));
  aclink_slot_shift #(.W(SLOT_W)) u_s1 (
    .clk_i, .rst_ni, .en_i(s1_en), .bit_i(sdo_i), .q_o(s1_q));
  aclink_slot_shift #(.W(SLOT_W)) u_s2 (
    .clk_i, .rst_ni, .en_i(s2_en), .bit_i(sdo_i), .q_o(s2_q));

  aclink_cmd_qualifier #(
    .TAG_BITS(TAG_W), .SLOT_BITS(SLOT_W), .ADDR_W(AW), .DATA_W(DW), .ID_W(IDW)
  ) u_qual (
    .clk_i, .rst_ni, .s2_last_i(s2_last), .tag_i(tag_q), .s1_i(s1_q), .s2_i(s2_q),
    .codec_id_i, .acc_valid_o, .acc_read_o, .acc_addr_o, .acc_wdata_o
  );
endmodule

// File: tb/aclink_cmd_decoder_test.sv
`timescale 1ns/1ps
module aclink_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdo = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        acc_valid, acc_read;
  logic [6:0]  acc_addr;
  logic [15:0] acc_wdata;

  int checks = 0;
  int errors = 0;
  logic        m_read = 1'b0;
  logic [6:0]  m_addr = '0;
  logic [15:0] m_data = '0;

  always #10 clk = ~clk;

  aclink_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sdo_i(sdo), .codec_id_i(strap),
    .acc_valid_o(acc_valid), .acc_read_o(acc_read), .acc_addr_o(acc_addr),
    .acc_wdata_o(acc_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic [15:0] tag, input logic [19:0] s1,
                                    input logic [1:0] id);
    if (!tag[15]) return 1'b0;
    if (id == 2'b00) return (tag[1:0] == 2'b00) && tag[14] && (s1[19] || tag[13]);
    return tag[1:0] == id;
  endfunction

  // drives len bits of a frame; samples outputs at each negedge before the next bit
  task automatic drive(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                       input int len, output int pcnt, output int pidx, output logic prd,
                       output logic [6:0] paddr, output logic [15:0] pdata);
    logic [255:0] fr;
    fr = {tag, s1, s2, 200'b0};
    for (int j = 0; j < 200; j++) fr[j] = 1'($urandom % 2);
    pcnt = 0; pidx = -1; prd = 0; paddr = 0; pdata = 0;
    for (int k = 0; k < len + 4; k++) begin
      @(negedge clk);
      if (acc_valid) begin
        pcnt++; pidx = k; prd = acc_read; paddr = acc_addr; pdata = acc_wdata;
      end
      if (k < len) begin
        sync = (k < 16);
        sdo  = fr[255-k];
      end else begin
        sync = 1'b0;
        sdo  = 1'b0;
      end
    end
  endtask

  task automatic frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                       input string req);
    int pcnt, pidx;
    logic prd;
    logic [6:0] paddr;
    logic [15:0] pdata;
    bit exp;
    exp = exp_accept(tag, s1, strap);
    drive(tag, s1, s2, 256, pcnt, pidx, prd, paddr, pdata);
    chk(pcnt == (exp ? 1 : 0), req, "strobe count", pcnt, exp ? 1 : 0);
    if (exp) begin
      m_read = s1[19];
      m_addr = s1[18:12];
      m_data = s1[19] ? 16'h0 : s2[19:4];
      chk(pidx == 57, "R8", "strobe bit slot", pidx, 57);
      chk(prd == m_read, "R7", "read flag", prd, m_read);
      chk(paddr == m_addr, "R1", "address", paddr, m_addr);
      chk(pdata == m_data, s1[19] ? "R9" : "R7", "write data", pdata, m_data);
    end
    chk(acc_addr == m_addr && acc_wdata == m_data && acc_read == m_read, "R10",
        "held outputs", {8'h0, acc_read, acc_addr, acc_wdata}, {8'h0, m_read, m_addr, m_data});
  endtask

  initial begin
    #3_800_000;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pcnt, pidx;
    logic prd;
    logic [6:0] paddr;
    logic [15:0] pdata;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!acc_valid && !acc_read && acc_addr == 0 && acc_wdata == 0, "R10", "reset state",
        {acc_valid, acc_read, acc_addr, acc_wdata}, 0);

    // primary strap
    strap = 2'b00;
    frame(16'hE000, {1'b0, 7'h26, 12'hABC}, 20'h1234F, "R3");
    frame(16'hC000, {1'b1, 7'h02, 12'h000}, 20'hFFFFF, "R3");
    frame(16'hC000, {1'b0, 7'h11, 12'h000}, 20'h55550, "R4");
    frame(16'h6000, {1'b0, 7'h33, 12'h000}, 20'h77770, "R2");
    frame(16'hE001, {1'b0, 7'h44, 12'h000}, 20'h88880, "R4");
    frame(16'hA000, {1'b1, 7'h45, 12'h000}, 20'h0, "R4");
    // secondary strap
    strap = 2'b10;
    frame(16'h8002, {1'b0, 7'h3E, 12'h0F0}, 20'hBEEF5, "R5");
    frame(16'h0002, {1'b0, 7'h12, 12'h000}, 20'h11110, "R2");
    frame(16'hE001, {1'b0, 7'h13, 12'h000}, 20'h22220, "R6");
    frame(16'hE000, {1'b1, 7'h14, 12'h000}, 20'h33330, "R6");
    frame(16'h8002, {1'b1, 7'h7F, 12'hFFF}, 20'hCAFE1, "R5");

    // truncated frame followed by a new sync rise
    drive(16'h8002, {1'b0, 7'h5A, 12'h0}, 20'h12340, 40, pcnt, pidx, prd, paddr, pdata);
    chk(pcnt == 0, "R11", "truncated frame strobe", pcnt, 0);
    frame(16'h8002, {1'b0, 7'h5B, 12'h0}, 20'h43210, "R11");

    // constrained random over all straps
    for (int p = 0; p < 4; p++) begin
      strap = 2'(p);
      for (int n = 0; n < 50; n++) begin
        logic [15:0] tag;
        tag = 16'($urandom);
        tag[15] = ($urandom % 4) != 0;
        if ($urandom % 4 != 0) tag[1:0] = strap;
        frame(tag, 20'($urandom), 20'($urandom), strap == 0 ? "R3" : "R5");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule